// File: doc/BRIEF.md
# Stuck-Bit Pointer Repair for Memory Lines

This block sits between a memory controller and a memory array whose cells wear out and stay stuck. It hides those permanent failures without a parity or syndrome code. For every line address it keeps a short list of repair slots. Each slot names one broken bit of the 512-bit line and holds the value that bit ought to have. When write verification finds a cell that did not take its value, the controller reports the line, the bit index and the intended value. The block claims the next free slot of that line for the failure.

On a read, the controller presents the raw line that came back from the array. The block overlays every active slot of that line onto the raw data and returns the repaired line one clock later. A later slot may name the same bit as an earlier one. The later slot then wins, so a slot whose own storage has gone bad can be superseded by a fresh one. On a line write, each active slot copies the new value of the bit it covers, so repairs follow the data. When a line has used all its slots and reports yet another failure, the report is dropped. A one-cycle overflow pulse and a sticky per-line uncorrectable flag mark the event.

Top module: `ecp_line_repair`

## Requirements
- R1: After reset every line has zero active slots, and a read of any line returns the raw input unchanged with `rd_used` = 0 and `rd_uncorr` = 0.
- R2: A read accepted on a clock edge (`rd_en` high) drives `rd_valid` high and the repaired line on `rd_data` after that same edge. `rd_valid` is low in every cycle that follows an edge without `rd_en`.
- R3: A failure report (`rep_valid` with line, bit index `rep_pos` and value `rep_bit`) on a line with a free slot makes every later read of that line return bit `rep_pos` equal to `rep_bit`, whatever the raw data holds there.
- R4: Slots of a line are claimed in ascending index order, 0 to 5, and `rd_used` on a read reports the number of claimed slots of that line. A report on one line leaves the slots and read data of every other line unchanged.
- R5: When two active slots of a line name the same bit index, the slot with the higher index sets that bit on read.
- R6: A line write (`wr_en`, `wr_line`, `wr_data`) sets the stored value of every active slot of that line to `wr_data` at that slot's bit index.
- R7: A read of a line whose six slots are all claimed returns `rd_used` = 6.
- R8: A report on a line with no free slot raises `rep_overflow` for exactly the one cycle after the report edge and sets that line's sticky uncorrectable flag, returned as `rd_uncorr` on reads of the line until reset.
- R9: A report on a line with no free slot changes no slot, so reads of that line return the same repaired data as before the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Line write strobe; updates slot values of that line |
| wr_line | input | 4 | Line address of the write |
| wr_data | input | 512 | Data written to the line |
| rep_valid | input | 1 | Failure report strobe from write verification |
| rep_line | input | 4 | Line address of the failed cell |
| rep_pos | input | 9 | Bit index of the failed cell within the line |
| rep_bit | input | 1 | Value the failed cell should hold |
| rd_en | input | 1 | Read strobe |
| rd_line | input | 4 | Line address of the read |
| rd_raw | input | 512 | Unrepaired line data from the array |
| rd_valid | output | 1 | Repaired read data valid |
| rd_data | output | 512 | Repaired line |
| rd_used | output | 3 | Slots claimed in the line that was read |
| rd_uncorr | output | 1 | Sticky uncorrectable flag of the line that was read |
| rep_overflow | output | 1 | One-cycle pulse: a report found no free slot |

## Verification
The bench repairs bit 0 and bit 511, the two ends of the index range. A block that mis-sized the index field or its lookup would patch the wrong cell or drop one end. It reports the same bit twice with opposite values. A block that resolved duplicates by the lowest index would return the stale value and could not retire a broken slot. It fills one line to six slots and then sends a seventh report. A block without a bounds guard would overwrite a slot or wrap the count, which shows up as changed read data or a wrong `rd_used`, and a block that lost the pulse or the sticky flag would give a silent overflow. Line writes after the repairs, and reads of untouched lines, catch slots whose values do not track the data and reports that leak into neighbouring lines.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  // Default geometry shared by the table, the patch stage and the top.
  localparam int unsigned DEF_LINE_W  = 512;
  localparam int unsigned DEF_ENTRIES = 6;
  localparam int unsigned DEF_LINES   = 16;
endpackage

// File: rtl/ecp_ptr_table.sv
module ecp_ptr_table #(
  parameter int unsigned N_LINES = ecp_pkg::DEF_LINES,
  parameter int unsigned N_ENT   = ecp_pkg::DEF_ENTRIES,
  parameter int unsigned LINE_W  = ecp_pkg::DEF_LINE_W,
  parameter int unsigned POS_W   = $clog2(LINE_W),
  parameter int unsigned LA_W    = $clog2(N_LINES),
  parameter int unsigned CNT_W   = $clog2(N_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [LA_W-1:0]          wr_line,
  input  logic [LINE_W-1:0]        wr_data,
  input  logic                     rep_valid,
  input  logic [LA_W-1:0]          rep_line,
  input  logic [POS_W-1:0]         rep_pos,
  input  logic                     rep_bit,
  input  logic [LA_W-1:0]          lk_line,
  output logic [N_ENT*POS_W-1:0]   lk_pos,
  output logic [N_ENT-1:0]         lk_val,
  output logic [CNT_W-1:0]         lk_cnt,
  output logic                     lk_unc,
  output logic                     ovf_o
);
  logic [POS_W-1:0] pos_q [N_LINES][N_ENT];
  logic [N_ENT-1:0] val_q [N_LINES];
  logic [CNT_W-1:0] cnt_q [N_LINES];
  logic [N_LINES-1:0] unc_q;
  logic               ovf_q;

  logic [CNT_W-1:0] rep_cnt;
  logic [CNT_W-1:0] wr_cnt;
  logic             rep_room;

  assign rep_cnt  = cnt_q[rep_line];
  assign wr_cnt   = cnt_q[wr_line];
  assign rep_room = (rep_cnt < CNT_W'(N_ENT));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < N_LINES; l++) begin
        cnt_q[l] <= '0;
        val_q[l] <= '0;
        for (int e = 0; e < N_ENT; e++) pos_q[l][e] <= '0;
      end
      unc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      // Active slots of a written line follow the new data.
      if (wr_en) begin
        for (int e = 0; e < N_ENT; e++) begin
          if (CNT_W'(e) < wr_cnt) val_q[wr_line][e] <= wr_data[pos_q[wr_line][e]];
        end
      end
      // A report claims the lowest free slot, or flags the line.
      if (rep_valid) begin
        if (rep_room) begin
          for (int e = 0; e < N_ENT; e++) begin
            if (CNT_W'(e) == rep_cnt) begin
              pos_q[rep_line][e] <= rep_pos;
              val_q[rep_line][e] <= rep_bit;
            end
          end
          cnt_q[rep_line] <= rep_cnt + CNT_W'(1);
        end else begin
          unc_q[rep_line] <= 1'b1;
        end
      end
      ovf_q <= rep_valid && !rep_room;
    end
  end

  always_comb begin
    for (int e = 0; e < N_ENT; e++) lk_pos[e*POS_W +: POS_W] = pos_q[lk_line][e];
  end
  assign lk_val = val_q[lk_line];
  assign lk_cnt = cnt_q[lk_line];
  assign lk_unc = unc_q[lk_line];
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/ecp_patch.sv
module ecp_patch #(
  parameter int unsigned N_ENT  = ecp_pkg::DEF_ENTRIES,
  parameter int unsigned LINE_W = ecp_pkg::DEF_LINE_W,
  parameter int unsigned POS_W  = $clog2(LINE_W),
  parameter int unsigned CNT_W  = $clog2(N_ENT + 1)
) (
  input  logic [LINE_W-1:0]       raw_i,
  input  logic [N_ENT*POS_W-1:0]  pos_i,
  input  logic [N_ENT-1:0]        val_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [LINE_W-1:0]       fix_o
);
  // Ascending walk: a later slot overrides an earlier one at the same bit.
  always_comb begin
    fix_o = raw_i;
    for (int e = 0; e < N_ENT; e++) begin
      if (CNT_W'(e) < cnt_i) fix_o[pos_i[e*POS_W +: POS_W]] = val_i[e];
    end
  end
endmodule

// File: rtl/ecp_line_repair.sv
module ecp_line_repair #(
  parameter int unsigned N_LINES = ecp_pkg::DEF_LINES,
  parameter int unsigned N_ENT   = ecp_pkg::DEF_ENTRIES,
  parameter int unsigned LINE_W  = ecp_pkg::DEF_LINE_W,
  parameter int unsigned POS_W   = $clog2(LINE_W),
  parameter int unsigned LA_W    = $clog2(N_LINES),
  parameter int unsigned CNT_W   = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LA_W-1:0]   wr_line,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              rep_valid,
  input  logic [LA_W-1:0]   rep_line,
  input  logic [POS_W-1:0]  rep_pos,
  input  logic              rep_bit,
  input  logic              rd_en,
  input  logic [LA_W-1:0]   rd_line,
  input  logic [LINE_W-1:0] rd_raw,
  output logic              rd_valid,
  output logic [LINE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_used,
  output logic              rd_uncorr,
  output logic              rep_overflow
);
  logic [N_ENT*POS_W-1:0] lk_pos;
  logic [N_ENT-1:0]       lk_val;
  logic [CNT_W-1:0]       lk_cnt;
  logic                   lk_unc;
  logic [LINE_W-1:0]      fixed;

  ecp_ptr_table #(
    .N_LINES(N_LINES), .N_ENT(N_ENT), .LINE_W(LINE_W),
    .POS_W(POS_W), .LA_W(LA_W), .CNT_W(CNT_W)
  ) table_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
    .rep_valid(rep_valid), .rep_line(rep_line), .rep_pos(rep_pos), .rep_bit(rep_bit),
    .lk_line(rd_line), .lk_pos(lk_pos), .lk_val(lk_val),
    .lk_cnt(lk_cnt), .lk_unc(lk_unc), .ovf_o(rep_overflow)
  );

  ecp_patch #(
    .N_ENT(N_ENT), .LINE_W(LINE_W), .POS_W(POS_W), .CNT_W(CNT_W)
  ) patch_i (
    .raw_i(rd_raw), .pos_i(lk_pos), .val_i(lk_val), .cnt_i(lk_cnt), .fix_o(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_used   <= '0;
      rd_uncorr <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data   <= fixed;
        rd_used   <= lk_cnt;
        rd_uncorr <= lk_unc;
      end
    end
  end
endmodule

// File: rtl/ecp_line_repair_chk.sv
module ecp_line_repair_chk #(
  parameter int unsigned N_ENT  = 6,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [LINE_W-1:0] rd_raw,
  input logic              rep_valid,
  input logic              rd_valid,
  input logic [LINE_W-1:0] rd_data,
  input logic [CNT_W-1:0]  rd_used,
  input logic              rd_uncorr,
  input logic              rep_overflow
);
  p_valid_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  p_no_slots_passthru_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_used == '0) |-> rd_data == $past(rd_raw));
  p_ovf_from_report_r8: assert property (@(posedge clk) disable iff (rst)
    rep_overflow |-> $past(rep_valid));
  p_uncorr_only_full_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_uncorr) |-> rd_used == CNT_W'(N_ENT));
  p_used_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_used <= CNT_W'(N_ENT));
endmodule

bind ecp_line_repair ecp_line_repair_chk #(
  .N_ENT(N_ENT), .LINE_W(LINE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_raw(rd_raw), .rep_valid(rep_valid),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_used(rd_used),
  .rd_uncorr(rd_uncorr), .rep_overflow(rep_overflow)
);

// File: tb/ecp_line_repair_tb.sv
`timescale 1ns/1ps
module ecp_line_repair_tb_top;
  localparam int LW = 512;
  localparam int NE = 6;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_line = '0;
  logic [LW-1:0] wr_data = '0;
  logic rep_valid = 1'b0;
  logic [3:0] rep_line = '0;
  logic [8:0] rep_pos = '0;
  logic rep_bit = 1'b0;
  logic rd_en = 1'b0;
  logic [3:0] rd_line = '0;
  logic [LW-1:0] rd_raw = '0;
  logic rd_valid;
  logic [LW-1:0] rd_data;
  logic [2:0] rd_used;
  logic rd_uncorr;
  logic rep_overflow;

  always #2 clk = ~clk;

  ecp_line_repair dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
    .rep_valid(rep_valid), .rep_line(rep_line), .rep_pos(rep_pos), .rep_bit(rep_bit),
    .rd_en(rd_en), .rd_line(rd_line), .rd_raw(rd_raw), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_used(rd_used), .rd_uncorr(rd_uncorr),
    .rep_overflow(rep_overflow)
  );

  // Report vectors: {line[3:0], pos[8:0], bit}
  localparam logic [13:0] VEC [12] = '{
    {4'd1, 9'd0,   1'b1},
    {4'd1, 9'd511, 1'b0},
    {4'd1, 9'd100, 1'b1},
    {4'd1, 9'd100, 1'b0},
    {4'd2, 9'd7,   1'b1},
    {4'd3, 9'd10,  1'b1},
    {4'd3, 9'd20,  1'b0},
    {4'd3, 9'd30,  1'b1},
    {4'd3, 9'd40,  1'b0},
    {4'd3, 9'd50,  1'b1},
    {4'd3, 9'd60,  1'b0},
    {4'd3, 9'd70,  1'b1}
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cnt [NL];
  int m_pos [NL][NE];
  bit m_val [NL][NE];
  bit m_unc [NL];

  function automatic void model_clear();
    for (int l = 0; l < NL; l++) begin
      m_cnt[l] = 0;
      m_unc[l] = 0;
      for (int e = 0; e < NE; e++) begin m_pos[l][e] = 0; m_val[l][e] = 0; end
    end
  endfunction

  function automatic logic [LW-1:0] pattern(int seed);
    logic [LW-1:0] p;
    for (int i = 0; i < LW; i++) p[i] = ((i * 7 + seed * 13) % 5) < 2;
    return p;
  endfunction

  function automatic logic [LW-1:0] expect_line(int ln, logic [LW-1:0] raw);
    logic [LW-1:0] r = raw;
    for (int e = 0; e < m_cnt[ln]; e++) r[m_pos[ln][e]] = m_val[ln][e];
    return r;
  endfunction

  task automatic check_vec(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(string req, int ln, logic [LW-1:0] raw);
    @(negedge clk);
    rd_en = 1'b1; rd_line = ln[3:0]; rd_raw = raw;
    @(negedge clk);
    rd_en = 1'b0;
    check_int({req, " valid (R2)"}, int'(rd_valid), 1);
    check_vec({req, " data"}, rd_data, expect_line(ln, raw));
    check_int({req, " used (R4/R7)"}, int'(rd_used), m_cnt[ln]);
    check_int({req, " uncorr (R8)"}, int'(rd_uncorr), int'(m_unc[ln]));
  endtask

  task automatic do_report(string req, int ln, int pos, bit b);
    bit full;
    full = (m_cnt[ln] == NE);
    @(negedge clk);
    rep_valid = 1'b1; rep_line = ln[3:0]; rep_pos = pos[8:0]; rep_bit = b;
    @(negedge clk);
    rep_valid = 1'b0;
    check_int({req, " overflow pulse (R8)"}, int'(rep_overflow), int'(full));
    if (full) m_unc[ln] = 1;
    else begin
      m_pos[ln][m_cnt[ln]] = pos;
      m_val[ln][m_cnt[ln]] = b;
      m_cnt[ln]++;
    end
  endtask

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: clean state after reset
    do_read("R1 reset line0", 0, pattern(1));
    do_read("R1 reset line3", 3, pattern(2));
    @(negedge clk);
    check_int("R2 idle valid low", int'(rd_valid), 0);

    // Table walk: R3 single repairs, R4 ascending fill, R5 duplicate, R7 full, R8 overflow
    foreach (VEC[i]) begin
      do_report("R3/R4 report", int'(VEC[i][13:10]), int'(VEC[i][9:1]), VEC[i][0]);
      do_read("R3/R5 read after report", int'(VEC[i][13:10]), pattern(i + 3));
    end

    // R5: duplicate index resolved by the later slot, raw bit 100 set to 1
    do_read("R5 dup later wins", 1, {LW{1'b1}});
    check_int("R5 bit100", int'(rd_data[100]), 0);
    // R3 ends of the index range on zero and one raw
    check_int("R3 bit0 forced", int'(rd_data[0]), 1);
    check_int("R3 bit511 forced", int'(rd_data[511]), 0);

    // R4: untouched line stays clean
    do_read("R4 other line clean", 0, pattern(20));
    check_int("R4 line0 used", int'(rd_used), 0);

    // R7/R9: full line, a further overflowing report leaves data alone
    do_read("R7 full line", 3, '0);
    check_int("R7 used six", int'(rd_used), NE);
    check_int("R9 bit70 not forced", int'(rd_data[70]), 0);
    do_report("R8 second overflow", 3, 200, 1'b1);
    @(negedge clk);
    check_int("R8 pulse one cycle", int'(rep_overflow), 0);
    do_read("R9 full line unchanged", 3, {LW{1'b1}});
    check_int("R9 bit200 raw", int'(rd_data[200]), 1);

    // R6: line write refreshes slot values
    @(negedge clk);
    wr_en = 1'b1; wr_line = 4'd1;
    wr_data = '0; wr_data[511] = 1'b1; wr_data[100] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int e = 0; e < m_cnt[1]; e++) m_val[1][e] = wr_data[m_pos[1][e]];
    do_read("R6 write refresh", 1, '0);
    check_int("R6 bit0", int'(rd_data[0]), 0);
    check_int("R6 bit511", int'(rd_data[511]), 1);
    check_int("R6 bit100", int'(rd_data[100]), 1);
    do_read("R6 other line untouched", 2, '0);

    // R1: a second reset clears all slots and flags
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    do_read("R1 after reset line1", 1, pattern(30));
    do_read("R1 after reset line3", 3, pattern(31));

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule